// File: doc/BRIEF.md
# Double-Buffered Timer with Two Compare Channels

This block is a 16-bit timer counter that advances on a one-cycle timer-clock enable and compares its value against two compare channels every cycle. A three-bit mode input chooses the count shape: a free-running or clear-on-compare up count, one of three fixed-period PWM counts, a PWM count whose period comes from channel 0, or an up/down (phase-correct) count whose turn-around point comes either from an external capture value or from channel 0.

Software loads each channel's compare value through a shared data input and a per-channel write strobe. In the two non-PWM modes a write reaches the live compare value at once. In the PWM modes the write lands in a holding buffer. The live value takes the buffer only at the end point of the count: TOP for single-slope modes and BOTTOM for up/down modes. Because a period never mixes two compare values, no odd-length pulses can appear.

The block drives combinational match and end-point strobes, and sticky compare and overflow flags that the interrupt logic or software clears.

Top module: `tmr16_dbcmp`

## Requirements
- R1: While `rst` is high at a clock edge, the count, the direction, every buffer, every live compare value and every flag are set to zero.
- R2: In a cycle with `tick` low and `cnt_wr` low, `count` keeps its value.
- R3: When `cnt_wr` is high, `count` takes `cnt_wdata` at that edge, whatever `tick` is. In that cycle there is no count step, no flag setting and no buffer load.
- R4: The mode codes set TOP as follows: 0 gives 0xFFFF, 1 gives live channel 0, 2 gives 0x00FF, 3 gives 0x01FF, 4 gives 0x03FF, and 5 gives live channel 0. In modes 0 to 5, each tick moves `count` to 0 if it equals TOP and otherwise adds one, wrapping at 16 bits.
- R5: In mode 6 (TOP = `top_ext`) and mode 7 (TOP = live channel 0), the count rises until it is at or above TOP, then falls to 0, then rises again. TOP and 0 are each held for one tick, and the turn happens on the tick taken at the end point.
- R6: `match[x]` is high exactly when `count` equals live channel x. `at_top` is high when `count` equals the current TOP. `at_bottom` is high when `count` is 0.
- R7: A tick taken while `match[x]` is high, with no counter write, sets `cmp_flag[x]` at that edge. The flag therefore appears one timer clock after the match.
- R8: A one on `flag_clr` clears a flag at the next edge. Bit 0 clears `ovf_flag` and bit 1+x clears `cmp_flag[x]`. If a flag is set and cleared in the same cycle, setting wins.
- R9: In modes 0 and 1, a compare write updates both the buffer and the live value at that edge.
- R10: In modes 2 to 7, a compare write updates only the buffer. The live value takes the buffer's old contents on a tick with `count` at TOP (modes 2 to 5) or at 0 (modes 6 and 7), and holds at all other times.
- R11: `ovf_flag` is set by a tick taken at TOP in modes 0 to 5, and by a tick taken at 0 in modes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable, one cycle per count step |
| mode | input | 3 | Count mode code, see R4 and R5 |
| top_ext | input | 16 | Captured period value used as TOP in mode 6 |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write data |
| cmp_wr | input | 2 | Per-channel compare write strobes |
| cmp_wdata | input | 16 | Compare write data, shared by both channels |
| flag_clr | input | 3 | Flag clear: bit 0 overflow, bit 1+x channel x |
| count | output | 16 | Counter value |
| at_top | output | 1 | Count equals current TOP |
| at_bottom | output | 1 | Count equals zero |
| match | output | 2 | Per-channel equality of count and live compare value |
| cmp_active | output | 32 | Live compare values, channel x in bits 16x+15:16x |
| cmp_flag | output | 2 | Sticky compare flags |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
`match`, `at_top` and `at_bottom` are combinational on registered state, so they are due in the same cycle as the state they describe. `count`, the live compare values and all flags change one edge after the inputs that cause them. The bench drives every input on the falling edge and steps its own model once per cycle. It compares every output at the next falling edge, after exactly one rising edge. Buffer loads and flag setting use the count and live values from before that edge. The model follows the same ordering, so a write that lands on the load edge is checked against the old buffer contents.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [2:0] {
        TM_FREE     = 3'd0,
        TM_CLR_A    = 3'd1,
        TM_PWM8     = 3'd2,
        TM_PWM9     = 3'd3,
        TM_PWM10    = 3'd4,
        TM_PWM_A    = 3'd5,
        TM_DUAL_EXT = 3'd6,
        TM_DUAL_A   = 3'd7
    } tmr_mode_e;

    // per-cycle events broadcast from the counter to the channels
    typedef struct packed {
        logic adv;   // a count step happens this cycle
        logic endpt; // step taken at the load / overflow point
    } tmr_evt_t;

    function automatic logic is_buffered(tmr_mode_e m);
        return !(m == TM_FREE || m == TM_CLR_A);
    endfunction

    function automatic logic is_dual(tmr_mode_e m);
        return (m == TM_DUAL_EXT || m == TM_DUAL_A);
    endfunction

    function automatic logic [CNT_W-1:0] top_of(tmr_mode_e m,
                                                 logic [CNT_W-1:0] ch0,
                                                 logic [CNT_W-1:0] ext);
        logic [CNT_W-1:0] t;
        case (m)
            TM_FREE:     t = '1;
            TM_PWM8:     t = CNT_W'(16'h00FF);
            TM_PWM9:     t = CNT_W'(16'h01FF);
            TM_PWM10:    t = CNT_W'(16'h03FF);
            TM_DUAL_EXT: t = ext;
            default:     t = ch0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/tmr16_count.sv
module tmr16_count
    import tmr16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] top,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         at_top,
    output logic         at_bottom,
    output tmr_evt_t     evt,
    output logic         ovf_flag
);

    logic         down;
    logic         nxt_down;
    logic [W-1:0] nxt;
    logic         dual;

    assign dual      = is_dual(mode);
    assign at_top    = (cnt == top);
    assign at_bottom = (cnt == '0);
    assign evt.adv   = tick && !wr;
    assign evt.endpt = evt.adv && (dual ? at_bottom : at_top);

    always_comb begin
        nxt      = cnt + W'(1);
        nxt_down = 1'b0;
        if (!dual) begin
            if (at_top) nxt = '0;
        end else if (!down) begin
            if (cnt >= top) begin
                nxt_down = 1'b1;
                nxt      = at_bottom ? cnt : cnt - W'(1);
            end
        end else if (!at_bottom) begin
            nxt_down = 1'b1;
            nxt      = cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            down     <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr)        cnt <= wdata;
            else if (tick) cnt <= nxt;
            if (!dual)        down <= 1'b0;
            else if (evt.adv) down <= nxt_down;
            ovf_flag <= evt.endpt | (ovf_flag & ~ovf_clr);
        end
    end

    a_r3_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr |=> cnt == $past(wdata));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr) |=> $stable(cnt));
    a_r11_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr && (dual ? cnt == '0 : cnt == top)) |=> ovf_flag);
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (!dual && tick && !wr && cnt == top) |=> cnt == '0);

endmodule

// File: rtl/tmr16_cmpch.sv
module tmr16_cmpch
    import tmr16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] cnt,
    input  tmr_evt_t     evt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] act,
    output logic         match,
    output logic         flag
);

    logic [W-1:0] hold_buf;
    logic         buffered;

    assign buffered = is_buffered(mode);
    assign match    = (cnt == act);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_buf <= '0;
            act      <= '0;
            flag     <= 1'b0;
        end else begin
            if (wr) hold_buf <= wdata;
            if (!buffered) begin
                if (wr) act <= wdata;
            end else if (evt.endpt) begin
                act <= hold_buf;
            end
            flag <= (evt.adv && match) | (flag & ~clr);
        end
    end

    a_r9_direct: assert property (@(posedge clk) disable iff (rst)
        (!buffered && wr) |=> act == $past(wdata));
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (buffered && !evt.endpt) |=> $stable(act));
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        (evt.adv && cnt == act) |=> flag);
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !(evt.adv && cnt == act)) |=> !flag);

endmodule

// File: rtl/tmr16_dbcmp.sv
module tmr16_dbcmp
    import tmr16_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [2:0]           mode,
    input  logic [CNT_W-1:0]     top_ext,
    input  logic                 cnt_wr,
    input  logic [CNT_W-1:0]     cnt_wdata,
    input  logic [NCH-1:0]       cmp_wr,
    input  logic [CNT_W-1:0]     cmp_wdata,
    input  logic [NCH:0]         flag_clr,
    output logic [CNT_W-1:0]     count,
    output logic                 at_top,
    output logic                 at_bottom,
    output logic [NCH-1:0]       match,
    output logic [NCH*CNT_W-1:0] cmp_active,
    output logic [NCH-1:0]       cmp_flag,
    output logic                 ovf_flag
);

    localparam int W = CNT_W;

    tmr_mode_e    md;
    tmr_evt_t     evt;
    logic [W-1:0] top;
    logic [W-1:0] act_w [NCH];

    assign md  = tmr_mode_e'(mode);
    assign top = top_of(md, act_w[0], top_ext);

    tmr16_count #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (md),
        .top      (top),
        .wr       (cnt_wr),
        .wdata    (cnt_wdata),
        .ovf_clr  (flag_clr[0]),
        .cnt      (count),
        .at_top   (at_top),
        .at_bottom(at_bottom),
        .evt      (evt),
        .ovf_flag (ovf_flag)
    );

    for (genvar x = 0; x < NCH; x++) begin : g_ch
        tmr16_cmpch #(.W(W)) u_ch (
            .clk  (clk),
            .rst  (rst),
            .mode (md),
            .cnt  (count),
            .evt  (evt),
            .wr   (cmp_wr[x]),
            .wdata(cmp_wdata),
            .clr  (flag_clr[x+1]),
            .act  (act_w[x]),
            .match(match[x]),
            .flag (cmp_flag[x])
        );
        assign cmp_active[x*W +: W] = act_w[x];
    end

    a_r6_bottom: assert property (@(posedge clk) disable iff (rst)
        at_bottom == (count == '0));

endmodule

// File: tb/sim_tmr16_dbcmp.sv
module sim_tmr16_dbcmp;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [2:0]  mode;
    logic [15:0] top_ext;
    logic        cnt_wr;
    logic [15:0] cnt_wdata;
    logic [1:0]  cmp_wr;
    logic [15:0] cmp_wdata;
    logic [2:0]  flag_clr;
    logic [15:0] count;
    logic        at_top, at_bottom;
    logic [1:0]  match;
    logic [31:0] cmp_active;
    logic [1:0]  cmp_flag;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [15:0] m_cnt;
    logic        m_down;
    logic [15:0] m_buf [2];
    logic [15:0] m_act [2];
    logic [1:0]  m_flag;
    logic        m_ovf;

    always #10 clk = ~clk;

    tmr16_dbcmp u0 (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode), .top_ext(top_ext),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .flag_clr(flag_clr), .count(count),
        .at_top(at_top), .at_bottom(at_bottom), .match(match),
        .cmp_active(cmp_active), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] f_top(input logic [2:0] md);
        case (md)
            3'd0: return 16'hFFFF;
            3'd2: return 16'h00FF;
            3'd3: return 16'h01FF;
            3'd4: return 16'h03FF;
            3'd6: return top_ext;
            default: return m_act[0];
        endcase
    endfunction

    // one clock: model next state from current inputs, then compare
    task automatic step();
        logic [15:0] tp, n_cnt;
        logic        dual, pwm, adv, endpt, n_down;
        logic [15:0] n_act [2];
        logic [1:0]  n_flag;
        tp    = f_top(mode);
        dual  = (mode >= 3'd6);
        pwm   = (mode >= 3'd2);
        adv   = tick && !cnt_wr;
        endpt = adv && (dual ? (m_cnt == 16'd0) : (m_cnt == tp));
        for (int x = 0; x < 2; x++) begin
            n_act[x] = m_act[x];
            if (!pwm && cmp_wr[x]) n_act[x] = cmp_wdata;
            else if (pwm && endpt)  n_act[x] = m_buf[x];
            n_flag[x] = (adv && m_cnt == m_act[x]) | (m_flag[x] & ~flag_clr[x+1]);
        end
        n_cnt  = m_cnt;
        n_down = m_down;
        if (!dual) n_down = 1'b0;
        if (cnt_wr) n_cnt = cnt_wdata;
        else if (tick) begin
            if (!dual) n_cnt = (m_cnt == tp) ? 16'd0 : m_cnt + 16'd1;
            else if (!m_down) begin
                if (m_cnt >= tp) begin
                    n_down = 1'b1;
                    n_cnt  = (m_cnt == 16'd0) ? 16'd0 : m_cnt - 16'd1;
                end else n_cnt = m_cnt + 16'd1;
            end else if (m_cnt == 16'd0) begin
                n_down = 1'b0;
                n_cnt  = 16'd1;
            end else n_cnt = m_cnt - 16'd1;
        end
        m_ovf = endpt | (m_ovf & ~flag_clr[0]);
        for (int x = 0; x < 2; x++) if (cmp_wr[x]) m_buf[x] = cmp_wdata;
        m_act  = n_act;
        m_flag = n_flag;
        m_cnt  = n_cnt;
        m_down = n_down;
        @(posedge clk);
        @(negedge clk);
        chk(dual ? "R5 count" : "R4 count", count, m_cnt);
        chk(pwm ? "R10 active0" : "R9 active0", cmp_active[15:0], m_act[0]);
        chk(pwm ? "R10 active1" : "R9 active1", cmp_active[31:16], m_act[1]);
        chk("R7 cmp_flag", cmp_flag, m_flag);
        chk("R11 ovf_flag", ovf_flag, m_ovf);
        chk("R6 match", match, {m_cnt == m_act[1], m_cnt == m_act[0]});
        chk("R6 at_top", at_top, m_cnt == f_top(mode));
        chk("R6 at_bottom", at_bottom, m_cnt == 16'd0);
    endtask

    task automatic idle_inputs();
        tick = 0; cnt_wr = 0; cmp_wr = 0; flag_clr = 0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual %0d expected below 150000", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; mode = 0; top_ext = 16'd40; cnt_wdata = 0; cmp_wdata = 0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_cnt = 0; m_down = 0; m_buf = '{16'd0, 16'd0}; m_act = '{16'd0, 16'd0};
        m_flag = 0; m_ovf = 0;
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 active", cmp_active, 0);
        chk("R1 flags", {cmp_flag, ovf_flag}, 0);

        // R3: counter write wins over a tick
        tick = 1; cnt_wr = 1; cnt_wdata = 16'd100;
        step();
        chk("R3 write priority", count, 16'd100);
        // R2: no tick holds the count
        idle_inputs();
        repeat (4) step();
        chk("R2 hold", count, 16'd100);

        // R10: buffered write in mode 2 waits for TOP
        mode = 3'd2; cnt_wr = 1; cnt_wdata = 16'h00FE;
        step();
        cnt_wr = 0; cmp_wr = 2'b01; cmp_wdata = 16'd7;
        step();
        chk("R10 not yet loaded", cmp_active[15:0], 0);
        cmp_wr = 0; tick = 1;
        repeat (2) step();
        chk("R10 loaded at TOP", cmp_active[15:0], 16'd7);
        chk("R11 wrap sets overflow", ovf_flag, 1);

        // R8: clear all flags with no tick
        idle_inputs();
        flag_clr = 3'b111;
        step();
        chk("R8 flags cleared", {cmp_flag, ovf_flag}, 0);
        flag_clr = 0;

        // random episodes per mode
        for (int ep = 0; ep < 16; ep++) begin
            logic [2:0] md;
            md = 3'(ep % 8);
            mode = md;
            top_ext = 16'($urandom_range(20, 80));
            idle_inputs();
            cnt_wr = 1; cnt_wdata = 0;
            step();
            for (int i = 0; i < 800; i++) begin
                tick     = ($urandom % 10) < 7;
                cmp_wr   = {($urandom % 25) == 0, ($urandom % 25) == 0};
                cmp_wdata = 16'($urandom_range(5, 90));
                cnt_wr   = ($urandom % 150) == 0;
                case (md)
                    3'd0: cnt_wdata = 16'hFFF0 + 16'($urandom_range(0, 15));
                    3'd2: cnt_wdata = 16'h00FF - 16'($urandom_range(0, 30));
                    3'd3: cnt_wdata = 16'h01FF - 16'($urandom_range(0, 30));
                    3'd4: cnt_wdata = 16'h03FF - 16'($urandom_range(0, 30));
                    default: cnt_wdata = 16'($urandom_range(0, 60));
                endcase
                flag_clr = (($urandom % 8) == 0) ? 3'($urandom) : 3'd0;
                step();
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule